// File: doc/BRIEF.md
# Windowed Watchdog with Slow-Clock Monitor

This block supervises a core from the instruction-cycle side. It divides the input clock into instruction cycles and runs two checkers on those cycle boundaries. A windowed watchdog expects a service strobe after a minimum number of cycles and before a selectable limit. A clock monitor watches a "clock is fast enough" indication from an analog detector.

The two checkers drive one shared, active-low error pin. The block presents this pin as an output-enable and a drive value. While neither checker reports a fault, the enable is low and the pin floats. Both checkers are held inert during reset. They are armed the moment reset ends, and the watchdog window starts at its widest setting.

A watchdog fault produces a fixed-length low pulse. A clock fault holds the pin low while the clock is slow, and for a bounded hold-off after the clock recovers.

Top module: `supv_wdog_cmon`

## Requirements
- R1: While `rst_n` is low, `err_oe` is 0 whatever `clk_ok` is. The internal reset is released on the second rising clock edge after `rst_n` rises.
- R2: An instruction-cycle boundary occurs once every `CYC_DIV` input clocks. The first boundary falls `CYC_DIV` clocks after the internal reset is released, which is the 12th rising edge after `rst_n` rises for `CYC_DIV`=10.
- R3: `err_oe` is 1 exactly when the watchdog or the clock monitor reports a fault. Whenever `err_oe` is 1, `err_val` is 0 (pin pulled low). Otherwise `err_val` is 1.
- R4: `clk_ok` passes through a two-flop synchronizer. At each boundary where the synchronized value is 0, a clock fault is raised on that edge. This includes the first boundary after reset.
- R5: A clock fault clears only after `CM_HOLD` (16) consecutive boundaries with the clock good. The pin is therefore released between 16 and 32 instruction cycles after `clk_ok` returns high.
- R6: After reset the window code is 3 (widest). Without any service, a watchdog fault occurs on the `WD_MAX`-th boundary after release.
- R7: The watchdog counts boundaries since its last restart. A fault is raised when the count reaches the limit for the current window code: code 3 = `WD_MAX`, 2 = `WD_MAX`/2, 1 = `WD_MAX`/4, 0 = `WD_MAX`/8. The count then restarts.
- R8: A service strobe that arrives while the count is below `WD_MIN` raises a watchdog fault.
- R9: Every service strobe restarts the count and loads `svc_win` as the new window code. A strobe with the count at or above `WD_MIN` raises no fault.
- R10: A watchdog fault holds its fault line for `WD_PULSE` (16) boundaries and then releases it by itself. A new fault restarts the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; instruction cycles are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc | input | 1 | One-clock watchdog service strobe |
| svc_win | input | 2 | Window code loaded with each service strobe |
| clk_ok | input | 1 | Clock-at-or-above-minimum indication, asynchronous |
| err_oe | output | 1 | Drive enable for the shared error pin |
| err_val | output | 1 | Value for the error pin (0 while driven) |

## Verification
Each result is due at a fixed clock after its cause. The internal reset clears two edges after `rst_n` rises, so the first boundary, and any slow-clock fault it reports, lands on the 12th edge. A low `clk_ok` reaches the monitor two edges after it changes. Watchdog faults and service-strobe faults register on the boundary edge or the strobe edge itself. The bench keeps a behavioural model that steps on every rising edge and compares the pin pair on every falling edge, so each result is checked one half-cycle after the edge that produced it. Longer intervals are measured by counting falling edges and comparing against bounds worked out from those latencies.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef logic [1:0] win_code_t;
  localparam win_code_t WIN_CODE_WIDEST = 2'b11;
endpackage

// File: rtl/supv_cycle_div.sv
module supv_cycle_div #(
  parameter int CYC_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == DW'(CYC_DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (CYC_DIV > 1) begin : g_chk
      // R2: boundaries are separated by at least one non-boundary clock
      a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/supv_clk_mon.sv
module supv_clk_mon #(
  parameter int CM_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clk_ok,
  output logic fault
);
  localparam int HW = (CM_HOLD > 1) ? $clog2(CM_HOLD) : 1;

  logic          ok_m_q, ok_s_q;
  logic          fault_q, fault_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    fault_d = fault_q;
    hold_d  = hold_q;
    if (tick) begin
      if (!ok_s_q) begin
        fault_d = 1'b1;
        hold_d  = '0;
      end else if (fault_q) begin
        if (hold_q == HW'(CM_HOLD - 1)) begin
          fault_d = 1'b0;
          hold_d  = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_m_q  <= 1'b0;
      ok_s_q  <= 1'b0;
      fault_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      ok_m_q  <= clk_ok;
      ok_s_q  <= ok_m_q;
      fault_q <= fault_d;
      hold_q  <= hold_d;
    end
  end

  assign fault = fault_q;

  // R4: a slow clock seen at a boundary always raises the fault
  a_r4_slow_clock_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ok_s_q) |=> fault_q);
  // R5: the fault only clears after a boundary that saw a good clock
  a_r5_release_needs_good_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(ok_s_q));
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int WD_MAX   = 65536,
  parameter int WD_MIN   = 2048,
  parameter int WD_PULSE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      svc,
  input  win_code_t svc_win,
  output logic      fault
);
  localparam int CW = $clog2(WD_MAX + 1);
  localparam int PW = $clog2(WD_PULSE + 1);

  win_code_t     win_q, win_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [PW-1:0] pls_q, pls_d;
  logic          early, late;

  always_comb begin
    unique case (win_q)
      2'b11:   lim = CW'(WD_MAX);
      2'b10:   lim = CW'(WD_MAX / 2);
      2'b01:   lim = CW'(WD_MAX / 4);
      default: lim = CW'(WD_MAX / 8);
    endcase
  end

  always_comb begin
    early = svc && (cnt_q < CW'(WD_MIN));
    late  = !svc && tick && (cnt_q == lim - 1'b1);
    win_d = svc ? svc_win : win_q;
    if (svc || late) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
    if (early || late)            pls_d = PW'(WD_PULSE);
    else if (tick && pls_q != '0) pls_d = pls_q - 1'b1;
    else                          pls_d = pls_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_CODE_WIDEST;
      cnt_q <= '0;
      pls_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign fault = (pls_q != '0);

  // R8: a strobe before the minimum count leads to a fault
  a_r8_early_service: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && cnt_q < CW'(WD_MIN)) |=> fault);
  // R7: reaching the window limit leads to a fault
  a_r7_window_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !svc && cnt_q == lim - 1'b1) |=> fault);
  // R9: each strobe loads the requested window code
  a_r9_window_loads: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (win_q == $past(svc_win)));
  // R10: a fault pulse never collapses in the cycle after it starts
  a_r10_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |=> fault);
endmodule

// File: rtl/supv_wdog_cmon.sv
module supv_wdog_cmon #(
  parameter int CYC_DIV  = 10,
  parameter int WD_MAX   = 65536,
  parameter int WD_MIN   = 2048,
  parameter int WD_PULSE = 16,
  parameter int CM_HOLD  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc,
  input  logic [1:0] svc_win,
  input  logic       clk_ok,
  output logic       err_oe,
  output logic       err_val
);
  logic rst_m_q, rst_s_q;
  logic tick, cm_fault, wd_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  supv_cycle_div #(.CYC_DIV(CYC_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_s_q),
    .tick (tick)
  );

  supv_clk_mon #(.CM_HOLD(CM_HOLD)) u_cmon (
    .clk   (clk),
    .rst_n (rst_s_q),
    .tick  (tick),
    .clk_ok(clk_ok),
    .fault (cm_fault)
  );

  supv_watchdog #(.WD_MAX(WD_MAX), .WD_MIN(WD_MIN), .WD_PULSE(WD_PULSE)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .tick   (tick),
    .svc    (svc),
    .svc_win(svc_win),
    .fault  (wd_fault)
  );

  assign err_oe  = cm_fault | wd_fault;
  assign err_val = ~err_oe;

  // R3: the pin is pulled low whenever it is driven
  a_r3_driven_low: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe |-> !err_val);
  // R1: no drive while the internal reset is still held
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s_q |-> !err_oe);
endmodule

// File: tb/supv_wdog_cmon_test.sv
module supv_wdog_cmon_test;
  localparam int DIV = 10, WMAX = 256, WMIN = 8, PULSE = 16, HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0, svc = 1'b0, clk_ok = 1'b0;
  logic [1:0] svc_win = 2'b00;
  logic err_oe, err_val;

  int checks = 0, errors = 0, cyc = 0;
  bit track = 1'b0;
  string phase = "R1";

  // behavioural model state
  int m_rs1, m_rs2, m_div, m_ok1, m_ok2, m_cm, m_hold, m_wc, m_win, m_pc;
  bit m_oe;

  supv_wdog_cmon #(.CYC_DIV(DIV), .WD_MAX(WMAX), .WD_MIN(WMIN),
                   .WD_PULSE(PULSE), .CM_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .svc(svc), .svc_win(svc_win),
    .clk_ok(clk_ok), .err_oe(err_oe), .err_val(err_val));

  always #2.5 clk = ~clk;

  task automatic model_clear(bit all);
    if (all) begin m_rs1 = 0; m_rs2 = 0; end
    m_div = 0; m_ok1 = 0; m_ok2 = 0; m_cm = 0; m_hold = 0;
    m_wc = 0; m_win = 3; m_pc = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear(1);
    else begin
      if (m_rs2 == 0) model_clear(0);
      else begin
        bit t, fire;
        int lim;
        t = (m_div == DIV - 1);
        m_div = t ? 0 : m_div + 1;
        if (t) begin
          if (m_ok2 == 0) begin m_cm = 1; m_hold = 0; end
          else if (m_cm == 1) begin
            if (m_hold == HOLD - 1) begin m_cm = 0; m_hold = 0; end
            else m_hold++;
          end
        end
        m_ok2 = m_ok1; m_ok1 = int'(clk_ok);
        lim = WMAX >> (3 - m_win);
        fire = 1'b0;
        if (svc) begin
          if (m_wc < WMIN) fire = 1'b1;
          m_wc = 0; m_win = int'(svc_win);
        end else if (t) begin
          if (m_wc == lim - 1) begin fire = 1'b1; m_wc = 0; end
          else m_wc++;
        end
        if (fire) m_pc = PULSE;
        else if (t && m_pc > 0) m_pc--;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
    m_oe = (m_cm != 0) || (m_pc != 0);
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (track) begin
      chk(err_oe === m_oe, phase, int'(err_oe), int'(m_oe));
      if (err_oe === 1'b1) chk(err_val === 1'b0, "R3", int'(err_val), 0);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    model_clear(1);
    m_oe = 1'b0;
    // R1: reset with a slow clock keeps the pin released
    repeat (5) @(negedge clk);
    track = 1'b1;
    chk(err_oe === 1'b0, "R1", int'(err_oe), 0);
    // R2 / R4: first boundary on the 12th edge flags the slow clock
    rst_n = 1'b1; phase = "R2";
    repeat (11) @(negedge clk);
    chk(err_oe === 1'b0, "R2", int'(err_oe), 0);
    @(negedge clk); phase = "R4";
    chk(err_oe === 1'b1, "R4", int'(err_oe), 1);
    repeat (20) @(negedge clk);
    // R5: hold-off after recovery
    phase = "R5"; clk_ok = 1'b1; n = 0;
    while (err_oe === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n >= 16 * DIV && n <= 32 * DIV, "R5", n, 16 * DIV);
    // R9: legal service, narrowest window
    phase = "R9";
    svc = 1'b1; svc_win = 2'b00; @(negedge clk); svc = 1'b0;
    repeat (100) @(negedge clk);
    chk(err_oe === 1'b0, "R9", int'(err_oe), 0);
    // R7: expiry of the eighth-size window
    phase = "R7"; n = 100;
    while (err_oe === 1'b0 && n < 2000) begin @(negedge clk); n++; end
    chk(n >= (WMAX / 8) * DIV - DIV && n <= (WMAX / 8) * DIV + DIV, "R7", n, (WMAX / 8) * DIV);
    // R10: fixed-length pulse
    phase = "R10"; n = 0;
    while (err_oe === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n >= (PULSE - 1) * DIV && n <= PULSE * DIV, "R10", n, PULSE * DIV);
    // R8: a legal strobe, then an early one
    phase = "R8";
    svc = 1'b1; svc_win = 2'b11; @(negedge clk); svc = 1'b0;
    repeat (2) @(negedge clk);
    chk(err_oe === 1'b0, "R9", int'(err_oe), 0);
    svc = 1'b1; @(negedge clk); svc = 1'b0;
    chk(err_oe === 1'b1, "R8", int'(err_oe), 1);
    n = 0;
    while (err_oe === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(err_oe === 1'b0, "R10", int'(err_oe), 0);
    // R3 / R4: slow clock mid-run
    phase = "R4"; clk_ok = 1'b0;
    repeat (30) @(negedge clk);
    chk(err_oe === 1'b1 && err_val === 1'b0, "R3", int'(err_val), 0);
    clk_ok = 1'b1; n = 0;
    while (err_oe === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n >= 16 * DIV && n <= 32 * DIV, "R5", n, 16 * DIV);
    // R1: reset during a slow clock
    phase = "R1"; clk_ok = 1'b0;
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(err_oe === 1'b0, "R1", int'(err_oe), 0);
    // R6: widest window after reset
    clk_ok = 1'b1; @(negedge clk);
    rst_n = 1'b1; phase = "R6";
    repeat (2500) @(negedge clk);
    chk(err_oe === 1'b0, "R6", int'(err_oe), 0);
    n = 2500;
    while (err_oe === 1'b0 && n < 3000) begin @(negedge clk); n++; end
    chk(n >= WMAX * DIV && n <= WMAX * DIV + 4, "R6", n, WMAX * DIV + 2);
    repeat (20) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule